// File: doc/BRIEF.md
# Configurable External Interrupt Conditioner

This block sits between 32 asynchronous interrupt pins from outside the chip and an interrupt controller that accepts only active-high level requests. Each pin has its own output request line. The block brings each pin into the clock domain and applies a per-line polarity. It then either passes the level through or turns a chosen edge into a held request. A final per-line mask decides whether that request reaches the controller.

Software sets up the block and services it through a small word-addressed register port. It selects per line between level and edge sensitivity, inverts the polarity where needed, masks lines, reads the raw pending state and acknowledges edge requests with a write-one-to-clear register. Masking blocks only the outgoing request. Edges that arrive on a masked line are still caught, so the request appears as soon as the line is unmasked.

Top module: `ext_irq_cond`

## Requirements
- R1: Each input bit irq_in[i] can affect only irq_out[i] and pending bit i. The other lines do not change.
- R2: Each input passes two synchroniser flops. In level mode with the line unmasked, a change on irq_in shows on irq_out at the fourth rising clock edge after it, and not before.
- R3: In level mode (trigger bit 0), pending bit i equals irq_in[i] XOR polarity bit i. Polarity 0 means active-high and 1 means active-low.
- R4: In edge mode (trigger bit 1), a rising edge (polarity 0) or a falling edge (polarity 1) of the synchronised input sets a sticky pending bit. The bit stays set after the input returns. The opposite edge does not set it.
- R5: Writing 1 to bit i of the edge-clear register (byte offset 0x10) clears an edge-mode pending bit at that write's clock edge. Bits written 0 leave their lines alone.
- R6: If a new edge is detected in the same cycle as a clear of the same line, the pending bit stays set.
- R7: Edge-clear writes have no effect on a line in level mode.
- R8: While mask bit i (byte offset 0x00, 1 = masked) is set, irq_out[i] stays low.
- R9: Detection and latching continue while a line is masked. A request caught while masked drives irq_out one cycle after the mask bit is cleared.
- R10: Register map (byte address, 32-bit words, combinational read): 0x00 mask, 0x04 polarity, 0x08 trigger type are read/write. 0x0C pending status is read-only, and writes to it are ignored. 0x10 edge-clear reads as 0. An access with reg_addr[1:0] not 00 is ignored and reads 0.
- R11: After reset, mask is all ones, polarity and trigger are all zeros, every pending bit is 0 and irq_out is 0.
- R12: irq_out is registered. It changes one clock after the pending or mask state that drives it changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 32 | Asynchronous external interrupt pins |
| irq_out | output | 32 | Active-high level requests to the interrupt controller |
| reg_wr_en | input | 1 | Register write strobe, sampled at the rising edge |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, a combinational function of reg_addr |

## Verification
Results fall due at three different times. A pin change reaches the pending status three rising edges later and irq_out four edges later. A register write changes the readable pending state at the edge that samples it. A mask or clear write reaches irq_out one edge after that. The bench drives every input at a falling edge and counts the rising edges before it samples. It checks each case once just before the result is due and once right after, most clearly for the latency of a pin change, the clear followed by output release, and the unmask followed by output assertion. The case where an edge and a clear land together is set up by starting the clear write one cycle after the pin change, so that both reach the pending bit at the same edge.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;
  // Word index of each register (byte address bits above the two low bits)
  localparam int unsigned REG_MASK = 0;
  localparam int unsigned REG_POL  = 1;
  localparam int unsigned REG_TRIG = 2;
  localparam int unsigned REG_STAT = 3;
  localparam int unsigned REG_CLR  = 4;
endpackage

// File: rtl/irq_cond_sync.sv
module irq_cond_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q, stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/irq_cond_line.sv
module irq_cond_line (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic pol_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic pend_o,
  output logic req_o
);
  logic last_q, last_d;
  logic pend_q, pend_d;
  logic req_q, req_d;
  logic cond, last_cond, hit;

  always_comb begin
    cond      = sync_i ^ pol_i;
    last_cond = last_q ^ pol_i;
    hit       = cond & ~last_cond;
    last_d    = sync_i;
    if (edge_mode_i) pend_d = hit | (pend_q & ~clr_i);
    else             pend_d = cond;
    req_d     = pend_q & ~mask_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      pend_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      last_q <= last_d;
      pend_q <= pend_d;
      req_q  <= req_d;
    end
  end

  assign pend_o = pend_q;
  assign req_o  = req_q;
endmodule

// File: rtl/irq_cond_regs.sv
module irq_cond_regs
  import irq_cond_pkg::*;
#(
  parameter int N  = 32,
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [N-1:0]  pend_i,
  output logic [N-1:0]  mask_o,
  output logic [N-1:0]  pol_o,
  output logic [N-1:0]  trig_o,
  output logic [N-1:0]  clr_o,
  output logic [DW-1:0] rdata
);
  localparam int IW = AW - 2;

  logic [IW-1:0] idx;
  logic          aligned;
  logic          we_mask, we_pol, we_trig;
  logic [N-1:0]  mask_q, mask_d, pol_q, pol_d, trig_q, trig_d;

  always_comb begin
    idx     = addr[AW-1:2];
    aligned = (addr[1:0] == 2'b00);
    we_mask = wr_en & aligned & (idx == IW'(REG_MASK));
    we_pol  = wr_en & aligned & (idx == IW'(REG_POL));
    we_trig = wr_en & aligned & (idx == IW'(REG_TRIG));
    mask_d  = we_mask ? wdata[N-1:0] : mask_q;
    pol_d   = we_pol  ? wdata[N-1:0] : pol_q;
    trig_d  = we_trig ? wdata[N-1:0] : trig_q;
    clr_o   = (wr_en & aligned & (idx == IW'(REG_CLR))) ? wdata[N-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      pol_q  <= '0;
      trig_q <= '0;
    end else begin
      mask_q <= mask_d;
      pol_q  <= pol_d;
      trig_q <= trig_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (aligned) begin
      if      (idx == IW'(REG_MASK)) rdata[N-1:0] = mask_q;
      else if (idx == IW'(REG_POL))  rdata[N-1:0] = pol_q;
      else if (idx == IW'(REG_TRIG)) rdata[N-1:0] = trig_q;
      else if (idx == IW'(REG_STAT)) rdata[N-1:0] = pend_i;
    end
  end

  assign mask_o = mask_q;
  assign pol_o  = pol_q;
  assign trig_o = trig_q;
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] irq_out,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic rst_meta, rst_ni;
  logic [NUM_LINES-1:0] sync, pend, mask, pol, trig, clr;

  // reset asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ni   <= rst_meta;
    end
  end

  irq_cond_sync #(.W(NUM_LINES), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_ni), .d(irq_in), .q(sync)
  );

  irq_cond_regs #(.N(NUM_LINES), .AW(ADDR_W), .DW(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_ni), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .pend_i(pend), .mask_o(mask), .pol_o(pol),
    .trig_o(trig), .clr_o(clr), .rdata(reg_rdata)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    irq_cond_line u_line (
      .clk(clk), .rst_n(rst_ni), .sync_i(sync[g]), .pol_i(pol[g]),
      .edge_mode_i(trig[g]), .clr_i(clr[g]), .mask_i(mask[g]),
      .pend_o(pend[g]), .req_o(irq_out[g])
    );
  end
endmodule

// File: rtl/ext_irq_cond_chk.sv
module ext_irq_cond_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] mask,
  input logic [N-1:0] pend,
  input logic [N-1:0] trig,
  input logic [N-1:0] clr,
  input logic [N-1:0] irq_out
);
  // R8
  masked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_out & $past(mask)) == '0));

  // R12
  out_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_out & ~$past(pend)) == '0));

  // R4
  edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(trig & pend & ~clr) & ~pend) == '0));

  // R11
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask == '1 && irq_out == '0));
endmodule

bind ext_irq_cond ext_irq_cond_chk #(.N(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_ni), .mask(mask), .pend(pend), .trig(trig),
  .clr(clr), .irq_out(irq_out)
);

// File: tb/test_ext_irq_cond.sv
module test_ext_irq_cond;
  localparam logic [4:0] A_MASK = 5'h00, A_POL = 5'h04, A_TRIG = 5'h08,
                         A_STAT = 5'h0C, A_CLR = 5'h10;

  typedef struct packed {
    logic [31:0] in, mask, pol, exp_out, exp_stat;
  } vec_t;

  // level-mode table (R3, R8, R1)
  localparam vec_t VECS [5] = '{
    '{32'hFFFF0000, 32'h00000000, 32'h00000000, 32'hFFFF0000, 32'hFFFF0000},
    '{32'hFFFF0000, 32'h00000000, 32'hFFFFFFFF, 32'h0000FFFF, 32'h0000FFFF},
    '{32'hA5A5A5A5, 32'h0F0F0F0F, 32'h00000000, 32'hA0A0A0A0, 32'hA5A5A5A5},
    '{32'h12345678, 32'h00000000, 32'hF0F0F0F0, 32'hE2C4A688, 32'hE2C4A688},
    '{32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic [31:0] irq_out;
  logic        reg_wr_en = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  ext_irq_cond i_ext_irq_cond (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_out(irq_out),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    cyc(3);
    rst_n = 1'b1;
    cyc(5);
    // R11 reset state
    rd(A_MASK, r); check("R11 mask", r, 32'hFFFFFFFF);
    rd(A_POL, r);  check("R11 pol", r, 32'h0);
    rd(A_TRIG, r); check("R11 trig", r, 32'h0);
    rd(A_STAT, r); check("R11 stat", r, 32'h0);
    check("R11 out", irq_out, 32'h0);

    // R10 register map
    wr(A_STAT, 32'hFFFFFFFF);
    rd(A_STAT, r); check("R10 stat read-only", r, 32'h0);
    rd(A_CLR, r);  check("R10 clear reads 0", r, 32'h0);
    wr(A_MASK, 32'h12345678); rd(A_MASK, r); check("R10 mask rw", r, 32'h12345678);
    wr(A_POL, 32'h9ABCDEF0);  rd(A_POL, r);  check("R10 pol rw", r, 32'h9ABCDEF0);
    wr(A_TRIG, 32'h0F0F0F0F); rd(A_TRIG, r); check("R10 trig rw", r, 32'h0F0F0F0F);
    wr(5'h01, 32'h0);         rd(A_MASK, r); check("R10 misaligned write", r, 32'h12345678);
    rd(5'h01, r); check("R10 misaligned read", r, 32'h0);

    // table walk: level mode
    wr(A_TRIG, 32'h0);
    for (int i = 0; i < 5; i++) begin
      wr(A_MASK, VECS[i].mask);
      wr(A_POL, VECS[i].pol);
      irq_in = VECS[i].in;
      cyc(6);
      rd(A_STAT, r);
      check($sformatf("R3 table %0d stat", i), r, VECS[i].exp_stat);
      check($sformatf("R8 table %0d out", i), irq_out, VECS[i].exp_out);
    end

    // R2 latency, R1 isolation
    wr(A_MASK, 32'h0); wr(A_POL, 32'h0);
    irq_in = 32'h0; cyc(5);
    irq_in = 32'h1;
    cyc(3); check("R2 not before 4th edge", irq_out, 32'h0);
    cyc(1); check("R2 R1 at 4th edge", irq_out, 32'h1);

    // edge mode, bit 7 level, bit 5 falling
    wr(A_TRIG, 32'hFFFFFF7F); wr(A_POL, 32'h20);
    irq_in = 32'h0; cyc(4);
    wr(A_CLR, 32'hFFFFFFFF); cyc(1);
    rd(A_STAT, r); check("R5 clear all", r, 32'h0);
    irq_in = 32'h8; cyc(3); irq_in = 32'h0; cyc(6);
    rd(A_STAT, r); check("R4 rising sticky", r, 32'h8);
    check("R4 out", irq_out, 32'h8);
    irq_in = 32'h20; cyc(6);
    rd(A_STAT, r); check("R4 wrong edge ignored", r, 32'h8);
    irq_in = 32'h0; cyc(6);
    rd(A_STAT, r); check("R4 falling sticky", r, 32'h28);

    wr(A_CLR, 32'h8);
    rd(A_STAT, r); check("R5 clear one", r, 32'h20);
    check("R12 out holds one cycle", irq_out, 32'h28);
    cyc(1); check("R12 out follows", irq_out, 32'h20);

    // R6 edge and clear in the same cycle
    wr(A_CLR, 32'h20);
    rd(A_STAT, r); check("R5 clear bit5", r, 32'h0);
    irq_in = 32'h20; cyc(6);
    irq_in = 32'h0; cyc(1);
    wr(A_CLR, 32'h20);
    rd(A_STAT, r); check("R6 edge wins", r, 32'h20);

    // R7 level line ignores clear
    irq_in = 32'h80; cyc(5);
    rd(A_STAT, r); check("R7 level pending", r, 32'hA0);
    wr(A_CLR, 32'h80);
    rd(A_STAT, r); check("R7 clear no effect", r, 32'hA0);
    irq_in = 32'h0; cyc(5);
    rd(A_STAT, r); check("R7 level follows", r, 32'h20);

    // R9 latch while masked
    wr(A_CLR, 32'hFFFFFFFF); wr(A_MASK, 32'hFFFFFFFF); cyc(2);
    irq_in = 32'h8; cyc(3); irq_in = 32'h0; cyc(5);
    rd(A_STAT, r); check("R9 latched masked", r, 32'h8);
    check("R8 masked out low", irq_out, 32'h0);
    wr(A_MASK, 32'h0);
    check("R12 unmask not yet", irq_out, 32'h0);
    cyc(1); check("R9 out after unmask", irq_out, 32'h8);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule